// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Command Sequencer

This block sits on the controller side of a two-bank synchronous DRAM with 2048 rows and 256 columns per bank. It drives the chip-select, row-strobe, column-strobe and write-enable pins, the clock enable, the byte masks and the shared address pins. All timing limits are whole clock counts set by parameters.

After reset it holds the device quiet for a fixed power-up interval. It then precharges both banks, issues a run of auto-refresh commands and programs the mode word. Once that sequence ends, it accepts single-word requests through a valid/ready handshake. Each request is served as an activate, followed by a read or write that carries the auto-precharge flag. A free-running interval counter asks for an auto-refresh at a fixed period. A refresh request that arrives while an access is under way is held pending and served before the next request is accepted. A one-cycle done pulse marks the clock in which the column command of a request is on the pins.

The request address packs the bank in its top bits, the row in the middle and the column in the low bits. Data capture and the write data path belong to neighbouring blocks.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted and until the power-up interval of T_POWERUP clocks after reset release has passed, the pins hold NOP, clock enable is high, every byte mask is high and req_ready is low. The first command appears T_POWERUP (at most T_POWERUP+1) clocks after release.
- R2: The start-up sequence is precharge with A10 high, then INIT_REFS auto-refresh commands, then the mode register write. The precharge-to-refresh gap is T_RP clocks, and each refresh is followed by the next command exactly T_RC clocks later.
- R3: The mode word on the address pins holds the burst-length code in bits 2..0 (1,2,4,8 map to 0,1,2,3), sequential order (bit 3 = 0), the CAS latency in bits 6..4 and burst write mode (bits 9..7 = 0). With CAS latency 2 and burst length 1 this is 12'h020.
- R4: req_ready stays low until the mode register write has been issued. The first activate comes at least T_MRD clocks after it. The byte masks go low with the mode write and remain low.
- R5: Once the start-up sequence is complete, an idle sequencer issues one auto-refresh every T_REFI clocks and no other command. No command follows a refresh sooner than T_RC clocks.
- R6: A request accepted at a clock edge puts an activate on the pins in the next cycle, with the bank on A11 and the row on A10..A0. The matching read or write follows exactly T_RCD clocks after the activate.
- R7: The column command carries the column on A7..A0, A10 high for auto-precharge and the bank on A11. It is a write when req_write was 1 at acceptance, otherwise a read.
- R8: After a read, the next command comes no sooner than RD_REC = max(CL+BL-2+T_RP, T_RC-T_RCD) clocks; after a write, no sooner than WR_REC = max(BL-1+T_WR+T_RP, T_RC-T_RCD). An activate for a request that is already waiting comes exactly at that gap.
- R9: A refresh that falls due during an access is served before the next activate. Under a continuous request stream, successive refreshes are no more than T_REFI+T_RCD+WR_REC+2 clocks apart.
- R10: req_done is high for exactly the cycles in which a read or write command is on the pins. The number of done pulses equals the number of accepted requests.
- R11: Pin encodings as {cs_n,ras_n,cas_n,we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode write 0000. No other value is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | {bank, row, column} |
| req_done | output | 1 | Pulse with the column command |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 2 | Byte masks |
| sd_addr | output | 12 | Address pins, A11 = bank |

## Verification
Two functions can collide in the same cycle: the refresh interval expiring and a request standing valid at the moment the sequencer returns to idle. The bench provokes this by holding req_valid high with fresh addresses across several refresh periods, so that expiries land in every phase of an activate and column-command pair. It judges the command log that results. Every refresh must precede the next activate, be followed by a gap of exactly T_RC before a waiting activate, and sit within the bounded distance of its predecessor. Done pulses must also match acceptances one for one.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS
   } sd_cmd_e;

   typedef enum logic [2:0] {
      S_PWRUP, S_PALL, S_INITREF, S_IDLE, S_ACTW
   } seq_state_e;

   // {cs_n, ras_n, cas_n, we_n}
   function automatic logic [3:0] cmd_pins(sd_cmd_e c);
      case (c)
         C_NOP:   return 4'b0111;
         C_ACT:   return 4'b0011;
         C_RD:    return 4'b0101;
         C_WR:    return 4'b0100;
         C_PRE:   return 4'b0010;
         C_REF:   return 4'b0001;
         C_MRS:   return 4'b0000;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [2:0] bl_code(int bl);
      case (bl)
         1:       return 3'd0;
         2:       return 3'd1;
         4:       return 3'd2;
         8:       return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int W         = 16,
   parameter int RESET_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= W'(RESET_VAL);
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ack,
   output logic pending
);
   generate
      if (INTERVAL == 0) begin : g_off
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, enable, ack};
         assign pending   = 1'b0;
      end else begin : g_on
         localparam int W = $clog2(INTERVAL + 1);
         localparam logic [W-1:0] RELOAD = W'(INTERVAL - 1);
         logic [W-1:0] cnt_q;
         logic         pend_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q  <= RELOAD;
               pend_q <= 1'b0;
            end else begin
               if (!enable || cnt_q == '0) cnt_q <= RELOAD;
               else                        cnt_q <= cnt_q - 1'b1;
               if (enable && cnt_q == '0)  pend_q <= 1'b1;
               else if (ack)               pend_q <= 1'b0;
            end
         end
         assign pending = pend_q;
      end
   endgenerate
endmodule

// File: rtl/sdram_pin_driver.sv
module sdram_pin_driver
   import sdram_seq_pkg::*;
#(
   parameter int AW    = 12,
   parameter int DQM_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sd_cmd_e          cmd,
   input  logic [AW-1:0]    addr_d,
   input  logic             mask,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [AW-1:0]    addr,
   output logic [DQM_W-1:0] dqm
);
   logic [3:0] pins_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins_q <= cmd_pins(C_NOP);
         addr   <= '0;
         dqm    <= '1;
      end else begin
         pins_q <= cmd_pins(cmd);
         addr   <= addr_d;
         dqm    <= mask ? '1 : '0;
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = pins_q;
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
   import sdram_seq_pkg::*;
#(
   parameter int BANK_W    = 1,
   parameter int ROW_W     = 11,
   parameter int COL_W     = 8,
   parameter int DQM_W     = 2,
   parameter int T_POWERUP = 40000,
   parameter int T_RP      = 2,
   parameter int T_RC      = 7,
   parameter int T_RCD     = 2,
   parameter int T_MRD     = 2,
   parameter int T_WR      = 2,
   parameter int CAS_LAT   = 2,
   parameter int BURST_LEN = 1,
   parameter int INIT_REFS = 2,
   parameter int T_REFI    = 3120
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
   output logic                            req_done,
   output logic                            sd_cke,
   output logic                            sd_cs_n,
   output logic                            sd_ras_n,
   output logic                            sd_cas_n,
   output logic                            sd_we_n,
   output logic [DQM_W-1:0]                sd_dqm,
   output logic [BANK_W+ROW_W-1:0]         sd_addr
);
   localparam int AP_BIT = 10;
   localparam int REQ_AW = BANK_W + ROW_W + COL_W;
   localparam int SD_AW  = BANK_W + ROW_W;
   localparam int RD_REC = imax(CAS_LAT + BURST_LEN - 2 + T_RP, T_RC - T_RCD);
   localparam int WR_REC = imax(BURST_LEN - 1 + T_WR + T_RP, T_RC - T_RCD);
   localparam int TMAX   = imax(imax(T_POWERUP, T_RC), imax(imax(RD_REC, WR_REC),
                                imax(T_RP, imax(T_RCD, T_MRD))));
   localparam int TW     = $clog2(TMAX + 1);
   localparam int RFW    = $clog2(INIT_REFS + 1);
   localparam logic [9:0] MODE10 = {3'b000, 3'(CAS_LAT), 1'b0, bl_code(BURST_LEN)};
   localparam logic [SD_AW-1:0] MODE_WORD = SD_AW'(MODE10);

   // elaboration-time parameter checks
   generate
      if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
         $error("CAS_LAT must be 2 or 3");
      end
      if (bl_code(BURST_LEN) == 3'd7) begin : g_bad_bl
         $error("BURST_LEN must be 1, 2, 4 or 8");
      end
      if (ROW_W <= AP_BIT || COL_W > AP_BIT) begin : g_bad_geom
         $error("row width must exceed and column width fit below the auto-precharge pin");
      end
      if (INIT_REFS < 2) begin : g_bad_nref
         $error("INIT_REFS must be at least 2");
      end
      if (T_POWERUP < 1 || T_RP < 1 || T_RC < 1 || T_RCD < 1 || T_MRD < 1) begin : g_bad_t
         $error("timing counts must be at least 1");
      end
   endgenerate

   seq_state_e              state_q, state_d;
   logic [RFW-1:0]          nref_q, nref_d;
   logic [BANK_W-1:0]       bank_q;
   logic [COL_W-1:0]        col_q;
   logic                    we_q;
   logic                    init_q;
   logic                    done_q, done_d;
   logic                    tmr_load, tmr_zero;
   logic [TW-1:0]           tmr_val;
   logic                    ref_pend, ref_ack;
   logic                    accept;
   sd_cmd_e                 cmd_d;
   logic [SD_AW-1:0]        addr_d;

   logic [BANK_W-1:0]       req_bank;
   logic [ROW_W-1:0]        req_row;
   logic [COL_W-1:0]        req_col;

   assign req_bank = req_addr[REQ_AW-1 -: BANK_W];
   assign req_row  = req_addr[COL_W +: ROW_W];
   assign req_col  = req_addr[COL_W-1:0];

   assign req_ready = (state_q == S_IDLE) && tmr_zero && !ref_pend;
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d  = state_q;
      nref_d   = nref_q;
      cmd_d    = C_NOP;
      addr_d   = '0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_ack  = 1'b0;
      done_d   = 1'b0;
      case (state_q)
         S_PWRUP: if (tmr_zero) begin
            cmd_d          = C_PRE;
            addr_d[AP_BIT] = 1'b1;
            tmr_load       = 1'b1;
            tmr_val        = TW'(T_RP - 1);
            state_d        = S_PALL;
         end
         S_PALL: if (tmr_zero) begin
            cmd_d    = C_REF;
            tmr_load = 1'b1;
            tmr_val  = TW'(T_RC - 1);
            nref_d   = RFW'(1);
            state_d  = S_INITREF;
         end
         S_INITREF: if (tmr_zero) begin
            tmr_load = 1'b1;
            if (nref_q < RFW'(INIT_REFS)) begin
               cmd_d   = C_REF;
               tmr_val = TW'(T_RC - 1);
               nref_d  = nref_q + 1'b1;
            end else begin
               cmd_d   = C_MRS;
               addr_d  = MODE_WORD;
               tmr_val = TW'(T_MRD - 1);
               state_d = S_IDLE;
            end
         end
         S_IDLE: if (tmr_zero) begin
            if (ref_pend) begin
               cmd_d    = C_REF;
               ref_ack  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TW'(T_RC - 1);
            end else if (req_valid) begin
               cmd_d                   = C_ACT;
               addr_d[ROW_W +: BANK_W] = req_bank;
               addr_d[ROW_W-1:0]       = req_row;
               tmr_load                = 1'b1;
               tmr_val                 = TW'(T_RCD - 1);
               state_d                 = S_ACTW;
            end
         end
         S_ACTW: if (tmr_zero) begin
            cmd_d                   = we_q ? C_WR : C_RD;
            addr_d[COL_W-1:0]       = col_q;
            addr_d[AP_BIT]          = 1'b1;
            addr_d[ROW_W +: BANK_W] = bank_q;
            tmr_load                = 1'b1;
            tmr_val                 = we_q ? TW'(WR_REC - 1) : TW'(RD_REC - 1);
            done_d                  = 1'b1;
            state_d                 = S_IDLE;
         end
         default: state_d = S_PWRUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_PWRUP;
         nref_q  <= '0;
         bank_q  <= '0;
         col_q   <= '0;
         we_q    <= 1'b0;
         init_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         nref_q  <= nref_d;
         done_q  <= done_d;
         if (cmd_d == C_MRS) init_q <= 1'b1;
         if (accept) begin
            bank_q <= req_bank;
            col_q  <= req_col;
            we_q   <= req_write;
         end
      end
   end

   sdram_gap_timer #(.W(TW), .RESET_VAL(T_POWERUP - 1)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdram_refresh_timer #(.INTERVAL(T_REFI)) u_refi (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (init_q),
      .ack     (ref_ack),
      .pending (ref_pend)
   );

   sdram_pin_driver #(.AW(SD_AW), .DQM_W(DQM_W)) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd_d),
      .addr_d (addr_d),
      .mask   (!(init_q || cmd_d == C_MRS)),
      .cs_n   (sd_cs_n),
      .ras_n  (sd_ras_n),
      .cas_n  (sd_cas_n),
      .we_n   (sd_we_n),
      .addr   (sd_addr),
      .dqm    (sd_dqm)
   );

   assign sd_cke   = 1'b1;
   assign req_done = done_q;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
   import sdram_seq_pkg::*;
#(
   parameter int T_RC  = 7,
   parameter int T_RCD = 2,
   parameter int AW    = 12,
   parameter int DQM_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_done,
   input logic             sd_cs_n,
   input logic             sd_ras_n,
   input logic             sd_cas_n,
   input logic             sd_we_n,
   input logic [AW-1:0]    sd_addr,
   input logic [DQM_W-1:0] sd_dqm
);
   localparam int CW = $clog2(imax(T_RC, T_RCD) + 2) + 1;

   logic [3:0]    pins;
   logic          is_act, is_ref, is_col;
   logic [CW-1:0] since_act, since_ref;
   logic          act_seen, ref_seen;

   assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_act = (pins == 4'b0011);
   assign is_ref = (pins == 4'b0001);
   assign is_col = (pins == 4'b0101) || (pins == 4'b0100);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '0;
         since_ref <= '0;
         act_seen  <= 1'b0;
         ref_seen  <= 1'b0;
      end else begin
         if (is_act) begin
            since_act <= CW'(1);
            act_seen  <= 1'b1;
         end else if (since_act != '1) since_act <= since_act + 1'b1;
         if (is_ref) begin
            since_ref <= CW'(1);
            ref_seen  <= 1'b1;
         end else if (since_ref != '1) since_ref <= since_ref + 1'b1;
      end
   end

   assert_accept_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> is_act);

   assert_rcd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (act_seen && since_act == CW'(T_RCD)));

   assert_ref_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_seen && pins != 4'b0111) |-> (since_ref >= CW'(T_RC)));

   assert_autopre_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> sd_addr[10]);

   assert_done_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> is_col);

   assert_col_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> req_done);

   assert_ready_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sd_dqm == '0));
endmodule

bind sdram_init_refresh_seq sdram_seq_chk #(
   .T_RC(T_RC), .T_RCD(T_RCD), .AW(BANK_W + ROW_W), .DQM_W(DQM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_done  (req_done),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_addr   (sd_addr),
   .sd_dqm    (sd_dqm)
);

// File: tb/sim_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_refresh_seq;
   localparam int P_PWR  = 60;
   localparam int P_RP   = 2;
   localparam int P_RC   = 4;
   localparam int P_RCD  = 3;
   localparam int P_MRD  = 2;
   localparam int P_WR   = 2;
   localparam int P_CL   = 2;
   localparam int P_BL   = 1;
   localparam int P_NREF = 3;
   localparam int P_REFI = 120;
   localparam int RD_REC = 3;   // max(2+1-2+2, 4-3)
   localparam int WR_REC = 4;   // max(0+2+2, 4-3)

   localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                          K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                          K_MRS = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_ready, req_done, sd_cke;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_dqm;
   logic [11:0] sd_addr;

   always #2.5 clk = ~clk;

   sdram_init_refresh_seq #(
      .T_POWERUP(P_PWR), .T_RP(P_RP), .T_RC(P_RC), .T_RCD(P_RCD), .T_MRD(P_MRD),
      .T_WR(P_WR), .CAS_LAT(P_CL), .BURST_LEN(P_BL), .INIT_REFS(P_NREF),
      .T_REFI(P_REFI)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_done(req_done),
      .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr)
   );

   wire [3:0] pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   int total = 0, bad = 0;
   int cyc = 0, rel_cyc = 0;
   int nlog = 0, ndone = 0, nacc = 0;
   int lc [0:1023];
   logic [3:0]  lk [0:1023];
   logic [11:0] la [0:1023];
   int dc [0:255];
   int unk_code = 0, done_odd = 0, early_ready = 0;
   bit mrs_seen = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (rst_n) begin
      if (pins != K_NOP && nlog < 1024) begin
         lc[nlog] = cyc; lk[nlog] = pins; la[nlog] = sd_addr; nlog++;
         if (!(pins inside {K_ACT, K_RD, K_WR, K_PRE, K_REF, K_MRS})) unk_code++;
      end
      if (req_done) begin
         if (ndone < 256) dc[ndone] = cyc;
         ndone++;
         if (!(pins inside {K_RD, K_WR})) done_odd++;
      end
      if (req_ready && !mrs_seen) early_ready++;
      if (pins == K_MRS) mrs_seen = 1;
      if (req_valid && req_ready) nacc++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int find_from(int start, logic [3:0] code);
      for (int i = start; i < nlog; i++) if (lk[i] == code) return i;
      return -1;
   endfunction

   task automatic do_req(input bit we, input logic [19:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_write = we; req_addr = a;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      repeat (5) @(negedge clk);
      chk(pins == K_NOP, "R1", "pins in reset", pins, K_NOP);
      chk(sd_cke == 1'b1, "R1", "cke in reset", sd_cke, 1);
      chk(sd_dqm == 2'b11, "R1", "dqm in reset", sd_dqm, 3);
      chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
      rst_n = 1'b1; rel_cyc = cyc;
      repeat (P_PWR / 2) @(negedge clk);
      chk(pins == K_NOP && sd_dqm == 2'b11 && sd_cke, "R1", "quiet during power-up",
          {pins, sd_dqm}, {K_NOP, 2'b11});
      chk(nlog == 0, "R1", "commands during power-up", nlog, 0);
   endtask

   task automatic t_init;
      int m;
      while (nlog < P_NREF + 2) @(negedge clk);
      chk(lk[0] == K_PRE, "R2", "first command precharge (R11 code)", lk[0], K_PRE);
      chk(la[0][10] == 1'b1, "R2", "precharge-all A10", la[0][10], 1);
      chk(lc[0] - rel_cyc >= P_PWR && lc[0] - rel_cyc <= P_PWR + 1, "R1",
          "power-up length", lc[0] - rel_cyc, P_PWR);
      for (int k = 1; k <= P_NREF; k++) begin
         chk(lk[k] == K_REF, "R2", "init refresh code", lk[k], K_REF);
         chk(lc[k] - lc[k-1] == ((k == 1) ? P_RP : P_RC), "R2", "init gap",
             lc[k] - lc[k-1], (k == 1) ? P_RP : P_RC);
      end
      m = P_NREF + 1;
      chk(lk[m] == K_MRS, "R2", "mode write code", lk[m], K_MRS);
      chk(lc[m] - lc[m-1] == P_RC, "R2", "refresh to mode write gap", lc[m] - lc[m-1], P_RC);
      chk(la[m] == 12'h020, "R3", "mode word", la[m], 12'h020);
      repeat (3) @(negedge clk);
      chk(early_ready == 0, "R4", "ready before mode write", early_ready, 0);
      chk(sd_dqm == 2'b00, "R4", "masks after init", sd_dqm, 0);
      chk(req_ready == 1'b1, "R4", "ready after init", req_ready, 1);
   endtask

   task automatic t_first_act;
      int s, ia, m;
      s = nlog; m = P_NREF + 1;
      do_req(1'b0, {1'b0, 11'h011, 8'h22});
      repeat (8) @(negedge clk);
      ia = find_from(s, K_ACT);
      chk(ia >= 0, "R4", "first activate present", ia, s);
      if (ia >= 0)
         chk(lc[ia] - lc[m] >= P_MRD, "R4", "mode write to activate", lc[ia] - lc[m], P_MRD);
   endtask

   task automatic t_access(input bit we, input bit bank, input logic [10:0] row,
                           input logic [7:0] col);
      int s, ia, ir;
      bit hit;
      s = nlog;
      do_req(we, {bank, row, col});
      repeat (10) @(negedge clk);
      ia = find_from(s, K_ACT);
      chk(ia >= 0 && ia + 1 < nlog, "R6", "activate logged", ia, s);
      if (ia >= 0 && ia + 1 < nlog) begin
         ir = ia + 1;
         chk(la[ia][11] == bank, "R6", "activate bank", la[ia][11], bank);
         chk(la[ia][10:0] == row, "R6", "activate row", la[ia][10:0], row);
         chk(lk[ir] == (we ? K_WR : K_RD), "R7", "column command kind (R11 code)",
             lk[ir], we ? K_WR : K_RD);
         chk(lc[ir] - lc[ia] == P_RCD, "R6", "activate to column gap", lc[ir] - lc[ia], P_RCD);
         chk(la[ir][7:0] == col, "R7", "column bits", la[ir][7:0], col);
         chk(la[ir][10] == 1'b1, "R7", "auto-precharge bit", la[ir][10], 1);
         chk(la[ir][11] == bank, "R7", "column bank", la[ir][11], bank);
         hit = 0;
         for (int d = 0; d < ndone && d < 256; d++) if (dc[d] == lc[ir]) hit = 1;
         chk(hit, "R10", "done pulse with column command", hit, 1);
      end
   endtask

   task automatic t_refresh_idle;
      int s, nr, prev, other;
      s = nlog; nr = 0; prev = -1; other = 0;
      repeat (3 * P_REFI + 10) @(negedge clk);
      for (int i = s; i < nlog; i++) begin
         if (lk[i] == K_REF) begin
            if (prev >= 0)
               chk(lc[i] - lc[prev] == P_REFI, "R5", "idle refresh period",
                   lc[i] - lc[prev], P_REFI);
            prev = i; nr++;
         end else other++;
      end
      chk(nr >= 2, "R5", "idle refresh count", nr, 3);
      chk(other == 0, "R5", "other commands while idle", other, 0);
   endtask

   task automatic t_stream;
      int s, nr, prev, gap;
      s = nlog; nr = 0; prev = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = {1'b1, 11'h0F0, 8'h01};
      repeat (450) begin
         @(negedge clk);
         if (req_ready) begin
            @(posedge clk); #1;
            req_write = ~req_write;
            req_addr  = req_addr + 20'h01101;
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      for (int i = s; i + 1 < nlog; i++) begin
         gap = lc[i+1] - lc[i];
         if (lk[i] == K_RD) begin
            chk(gap >= RD_REC, "R8", "read recovery", gap, RD_REC);
            if (lk[i+1] == K_ACT) chk(gap == RD_REC, "R8", "read to waiting activate", gap, RD_REC);
         end else if (lk[i] == K_WR) begin
            chk(gap >= WR_REC, "R8", "write recovery", gap, WR_REC);
            if (lk[i+1] == K_ACT) chk(gap == WR_REC, "R8", "write to waiting activate", gap, WR_REC);
         end else if (lk[i] == K_REF) begin
            chk(gap >= P_RC, "R5", "refresh spacing under load", gap, P_RC);
            if (lk[i+1] == K_ACT) chk(gap == P_RC, "R9", "refresh to waiting activate", gap, P_RC);
         end else if (lk[i] == K_ACT) begin
            chk(lk[i+1] inside {K_RD, K_WR} && gap == P_RCD, "R6", "activate then column",
                gap, P_RCD);
         end
         if (lk[i] == K_REF) begin
            if (prev >= 0)
               chk(lc[i] - lc[prev] <= P_REFI + P_RCD + WR_REC + 2, "R9",
                   "refresh distance under load", lc[i] - lc[prev], P_REFI);
            prev = i; nr++;
         end
      end
      chk(nr >= 2, "R9", "refreshes served under load", nr, 3);
      chk(done_odd == 0, "R10", "done without column command", done_odd, 0);
      chk(ndone == nacc, "R10", "done count vs accepted", ndone, nacc);
      chk(unk_code == 0, "R11", "unknown pin codes", unk_code, 0);
   endtask

   initial begin
      t_reset;
      t_init;
      t_first_act;
      t_access(1'b0, 1'b1, 11'h5A3, 8'h3C);
      t_access(1'b1, 1'b0, 11'h2F0, 8'hC5);
      t_refresh_idle;
      t_stream;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule